// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recent page translations and answers lookups before any page-table walk is needed. A lookup presents a virtual page number and an access kind (read or write). One cycle later the block answers with a hit and the physical frame, a miss that asks the outside walker to fetch the translation, or a permission fault. After a walk, the walker writes the translation in through the fill port. Software or a coherence agent can drop stale translations, either for one address or for the whole array.

Each entry can stand for a 4 KB, 2 MB or 1 GB page. A size code in the entry hides the low 9 or 18 page-number bits from the comparison, so one entry can cover a whole large page. For a large page, the frame returned on a hit takes those low bits from the lookup. Any entry may hold any translation. A fill goes to the lowest free slot. When no slot is free, a round-robin pointer picks the slot to replace.

The response path is a four-state machine. RS_IDLE means no lookup came in the previous cycle. RS_HIT means the entry matched and the access is allowed. RS_MISS means no entry matched. RS_FAULT means an entry matched but the access kind is not allowed. On every clock edge the machine moves from whatever state it is in to RS_IDLE if there is no lookup. If there is a lookup, it moves to RS_MISS when nothing matches, to RS_FAULT when the permission check fails, and to RS_HIT otherwise.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid and no response is shown, so the first lookup after reset misses.
- R2: A lookup sampled at a clock edge gives exactly one of hit, miss or fault, together with rsp_valid, in the next cycle. With no lookup, rsp_valid is low.
- R3: A lookup that matches a 4 KB entry (size code 0) returns that entry's frame number.
- R4: Size code 1 (2 MB) leaves the low 9 page-number bits out of the match, and size code 2 (1 GB) leaves out the low 18. On a hit, those low bits of the returned frame come from the lookup page number, and the upper bits come from the entry.
- R5: Each entry has a read-allow bit and a write-allow bit. A lookup whose access kind is not allowed gives rsp_fault instead of a hit, with rsp_pfn at zero.
- R6: A lookup that matches no valid entry gives rsp_miss for one cycle, with rsp_pfn at zero.
- R7: A fill goes to the lowest-numbered invalid slot, so free slots are used before any valid entry is replaced.
- R8: When every slot is valid, a fill replaces the slot named by a round-robin pointer. The pointer starts at 0 and steps by one, wrapping, on each such replacement.
- R9: An invalidate by address clears every valid entry whose size-masked page number matches the address, including large-page entries that cover it. Other entries are kept.
- R10: A flush clears all entries.
- R11: When a fill and an invalidate or flush come in the same cycle, the invalidate is applied first. The filled entry survives, and a slot freed by that invalidate can take the fill.
- R12: A lookup is matched against the contents from before any fill or invalidate in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_write | input | 1 | Lookup access kind: 1 write, 0 read |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_size | input | 2 | Page size code: 0 4 KB, 1 2 MB, 2 1 GB |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| inv_valid | input | 1 | Invalidate entries that cover inv_vpn |
| inv_vpn | input | VPN_W | Page number to invalidate |
| inv_all | input | 1 | Flush all entries |
| rsp_valid | output | 1 | A lookup result is shown |
| rsp_hit | output | 1 | Lookup hit with permission |
| rsp_miss | output | 1 | Lookup miss; start a walk |
| rsp_fault | output | 1 | Lookup matched but the access is not allowed |
| rsp_pfn | output | PFN_W | Translated frame on a hit, zero otherwise |

## Verification
A fill can land in the same cycle as an invalidate by address or a flush, and a lookup can land in the same cycle as either of them. The bench drives such pairs together on one clock edge. It first checks that a lookup issued in that cycle still reflects the old contents. It then checks, through later lookups, that the filled entry is present and the invalidated ones are gone. With the array full, it also pairs an invalidate with a fill and confirms that the freed slot, not the round-robin victim, took the fill: the victim's translation must still hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_2M   = 2'd1,
        PG_1G   = 2'd2,
        PG_RSVD = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS,
        RS_FAULT
    } rsp_state_e;

    // Low page-number bits hidden by a page-size code (lvl bits per level).
    function automatic logic [63:0] span_mask(input logic [1:0] sz, input int unsigned lvl);
        logic [63:0] m;
        if (sz == PG_2M)
            m = (64'd1 << lvl) - 64'd1;
        else if (sz == PG_1G)
            m = (64'd1 << (2 * lvl)) - 64'd1;
        else
            m = 64'd0;
        return m;
    endfunction

endpackage

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
    parameter int N        = 16,
    parameter int VPN_W    = 36,
    parameter int LVL_BITS = 9
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][VPN_W-1:0] ent_vpn,
    input  logic [N-1:0][1:0]       ent_size,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            match
);
    import xlat_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VPN_W-1:0] hide;
        always_comb begin
            hide     = VPN_W'(span_mask(ent_size[g], LVL_BITS));
            match[g] = ent_valid[g] && (((ent_vpn[g] ^ key) & ~hide) == '0);
        end
    end

endmodule

// File: rtl/xlat_fill_pick.sv
module xlat_fill_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [N-1:0]     occupied,
    output logic [IDX_W-1:0] slot
);
    logic [IDX_W-1:0] rr_q;
    logic             found;

    always_comb begin
        found = 1'b0;
        slot  = rr_q;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fill_en && !found)
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    // R8: the pointer moves only when a valid entry is replaced
    assert_rr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && !found) |=> $stable(rr_q));
    // R7: a free slot is never displaced by the pointer choice
    assert_free_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && occupied != '1) |-> !occupied[slot]);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int ENTRIES  = 16,
    parameter int VPN_W    = 36,
    parameter int PFN_W    = 28,
    parameter int LVL_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_size,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             inv_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PFN_W-1:0] rsp_pfn
);
    import xlat_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage
    logic [ENTRIES-1:0]            ent_valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn_q;
    logic [ENTRIES-1:0][1:0]       ent_size_q;
    logic [ENTRIES-1:0]            ent_rd_q;
    logic [ENTRIES-1:0]            ent_wr_q;

    // Parallel compare for lookup and for invalidate
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] inv_match;

    xlat_cam_match #(.N(ENTRIES), .VPN_W(VPN_W), .LVL_BITS(LVL_BITS)) u_lk_match (
        .ent_valid (ent_valid_q),
        .ent_vpn   (ent_vpn_q),
        .ent_size  (ent_size_q),
        .key       (lk_vpn),
        .match     (lk_match)
    );

    xlat_cam_match #(.N(ENTRIES), .VPN_W(VPN_W), .LVL_BITS(LVL_BITS)) u_inv_match (
        .ent_valid (ent_valid_q),
        .ent_vpn   (ent_vpn_q),
        .ent_size  (ent_size_q),
        .key       (inv_vpn),
        .match     (inv_match)
    );

    // Invalidate first, then choose a slot for the fill
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] survive;
    logic [ENTRIES-1:0] valid_d;
    logic [IDX_W-1:0]   fill_slot;

    always_comb begin
        kill    = inv_all ? '1 : (inv_valid ? inv_match : '0);
        survive = ent_valid_q & ~kill;
        valid_d = survive;
        if (fill_valid)
            valid_d[fill_slot] = 1'b1;
    end

    xlat_fill_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .occupied (survive),
        .slot     (fill_slot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ent_valid_q <= '0;
        else
            ent_valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            ent_vpn_q[fill_slot]  <= fill_vpn;
            ent_pfn_q[fill_slot]  <= fill_pfn;
            ent_size_q[fill_slot] <= fill_size;
            ent_rd_q[fill_slot]   <= fill_rd;
            ent_wr_q[fill_slot]   <= fill_wr;
        end
    end

    // Lookup: pick the lowest matching entry and form the frame
    logic             lk_any;
    logic [IDX_W-1:0] lk_sel;
    logic [PFN_W-1:0] keep_low;
    logic [PFN_W-1:0] pfn_d;
    logic             perm_ok;

    always_comb begin
        lk_any = |lk_match;
        lk_sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i])
                lk_sel = IDX_W'(i);
        end
        keep_low = PFN_W'(span_mask(ent_size_q[lk_sel], LVL_BITS));
        pfn_d    = (ent_pfn_q[lk_sel] & ~keep_low) | (PFN_W'(lk_vpn) & keep_low);
        perm_ok  = lk_write ? ent_wr_q[lk_sel] : ent_rd_q[lk_sel];
    end

    // Response state machine
    rsp_state_e       state_q;
    rsp_state_e       state_d;
    logic [PFN_W-1:0] pfn_q;

    always_comb begin
        if (!lk_valid)
            state_d = RS_IDLE;
        else if (!lk_any)
            state_d = RS_MISS;
        else if (!perm_ok)
            state_d = RS_FAULT;
        else
            state_d = RS_HIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            pfn_q   <= '0;
        end else begin
            state_q <= state_d;
            pfn_q   <= (state_d == RS_HIT) ? pfn_d : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        rsp_pfn   = '0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_pfn   = pfn_q;
            end
            RS_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            RS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: one response per lookup, in the next cycle
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R6: a lookup against an empty array misses
    assert_empty_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ent_valid_q == '0) |=> rsp_miss);
    // R7: a fill leaves its slot valid
    assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> ent_valid_q[$past(fill_slot)]);
    // R9: address invalidate removes all covering entries
    assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_all && !fill_valid) |=> (ent_valid_q & $past(inv_match)) == '0);
    // R10: flush empties the array
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fill_valid) |=> ent_valid_q == '0);
    // R11: flush with a fill keeps exactly the filled entry
    assert_flush_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && fill_valid) |=> $countones(ent_valid_q) == 1);

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

    localparam int VW = 36;
    localparam int PW = 28;

    localparam logic [1:0] OP_LK = 2'd0, OP_FILL = 2'd1, OP_INV = 2'd2, OP_FLUSH = 2'd3;
    localparam logic [2:0] E_NONE = 3'd0, E_HIT = 3'd1, E_MISS = 3'd2, E_FAULT = 3'd3;

    typedef struct packed {
        logic [1:0]    op;
        logic [VW-1:0] vpn;
        logic [PW-1:0] pfn;
        logic [1:0]    sz;
        logic          rd;
        logic          wr;
        logic          wrt;
        logic [2:0]    exp;
        logic [PW-1:0] epfn;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{OP_LK,   36'h100,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_MISS,  28'h0,      8'd1},  // R1 empty
        '{OP_FILL, 36'h1234,  28'habc,    2'd0, 1'b1, 1'b1, 1'b0, E_NONE,  28'h0,      8'd2},
        '{OP_LK,   36'h1234,  28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_HIT,   28'habc,    8'd3},  // R3
        '{OP_LK,   36'h1235,  28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_MISS,  28'h0,      8'd6},  // R6
        '{OP_LK,   36'h1234,  28'h0,      2'd0, 1'b0, 1'b0, 1'b1, E_HIT,   28'habc,    8'd5},  // R5 write ok
        '{OP_FILL, 36'h400,   28'h8000,   2'd1, 1'b1, 1'b0, 1'b0, E_NONE,  28'h0,      8'd2},
        '{OP_LK,   36'h5A5,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_HIT,   28'h81A5,   8'd4},  // R4 2M
        '{OP_LK,   36'h5A5,   28'h0,      2'd0, 1'b0, 1'b0, 1'b1, E_FAULT, 28'h0,      8'd5},  // R5 read-only
        '{OP_LK,   36'h600,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_MISS,  28'h0,      8'd4},  // R4 outside
        '{OP_FILL, 36'h80000, 28'h100000, 2'd2, 1'b1, 1'b1, 1'b0, E_NONE,  28'h0,      8'd2},
        '{OP_LK,   36'hBFFFF, 28'h0,      2'd0, 1'b0, 1'b0, 1'b1, E_HIT,   28'h13FFFF, 8'd4},  // R4 1G
        '{OP_LK,   36'hC0000, 28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_MISS,  28'h0,      8'd4},  // R4 outside
        '{OP_FILL, 36'h777,   28'h55,     2'd0, 1'b0, 1'b1, 1'b0, E_NONE,  28'h0,      8'd2},
        '{OP_LK,   36'h777,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_FAULT, 28'h0,      8'd5},  // R5 no read
        '{OP_LK,   36'h777,   28'h0,      2'd0, 1'b0, 1'b0, 1'b1, E_HIT,   28'h55,     8'd5},  // R5
        '{OP_INV,  36'h4FF,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_NONE,  28'h0,      8'd9},
        '{OP_LK,   36'h5A5,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_MISS,  28'h0,      8'd9},  // R9 2M gone
        '{OP_LK,   36'h1234,  28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_HIT,   28'habc,    8'd9},  // R9 kept
        '{OP_INV,  36'h90000, 28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_NONE,  28'h0,      8'd9},
        '{OP_LK,   36'hBFFFF, 28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_MISS,  28'h0,      8'd9},  // R9 1G gone
        '{OP_LK,   36'h777,   28'h0,      2'd0, 1'b0, 1'b0, 1'b1, E_HIT,   28'h55,     8'd9},  // R9 kept
        '{OP_FILL, 36'hA00,   28'h9FF,    2'd1, 1'b1, 1'b1, 1'b0, E_NONE,  28'h0,      8'd2},
        '{OP_LK,   36'hA03,   28'h0,      2'd0, 1'b0, 1'b0, 1'b0, E_HIT,   28'h803,    8'd4}   // R4 low bits
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lk_valid, lk_write, fill_valid, fill_rd, fill_wr, inv_valid, inv_all;
    logic [VW-1:0] lk_vpn, fill_vpn, inv_vpn;
    logic [PW-1:0] fill_pfn;
    logic [1:0]    fill_size;
    logic          rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [PW-1:0] rsp_pfn;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn)
    );

    task automatic idle_all();
        lk_valid = 1'b0; lk_vpn = '0; lk_write = 1'b0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_size = 2'd0;
        fill_rd = 1'b0; fill_wr = 1'b0;
        inv_valid = 1'b0; inv_vpn = '0; inv_all = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_all();
    endtask

    task automatic check(input string tag, input logic [2:0] exp, input logic [PW-1:0] epfn);
        logic [2:0] got;
        got = !rsp_valid ? E_NONE : rsp_hit ? E_HIT : rsp_miss ? E_MISS : rsp_fault ? E_FAULT : 3'd7;
        if ((rsp_hit + rsp_miss + rsp_fault) > 1) got = 3'd7;
        n_checks++;
        if (got !== exp || rsp_pfn !== epfn) begin
            n_fail++;
            $display("FAIL %s: got code %0d pfn %h, expected code %0d pfn %h",
                     tag, got, rsp_pfn, exp, epfn);
        end
    endtask

    task automatic set_fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                            input logic [1:0] s, input logic r, input logic w);
        fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_size = s; fill_rd = r; fill_wr = w;
    endtask

    task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p);
        set_fill(v, p, 2'd0, 1'b1, 1'b1);
        step();
    endtask

    task automatic look(input logic [VW-1:0] v, input string tag,
                        input logic [2:0] exp, input logic [PW-1:0] epfn);
        lk_valid = 1'b1; lk_vpn = v; lk_write = 1'b0;
        step();
        check(tag, exp, epfn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset idle", E_NONE, '0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            unique case (VECS[k].op)
                OP_LK: begin
                    lk_valid = 1'b1; lk_vpn = VECS[k].vpn; lk_write = VECS[k].wrt;
                end
                OP_FILL: set_fill(VECS[k].vpn, VECS[k].pfn, VECS[k].sz, VECS[k].rd, VECS[k].wr);
                OP_INV: begin
                    inv_valid = 1'b1; inv_vpn = VECS[k].vpn;
                end
                default: inv_all = 1'b1;
            endcase
            step();
            check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].exp, VECS[k].epfn);
        end

        // R12: lookup in the fill cycle sees old contents
        set_fill(36'h3333, 28'h333, 2'd0, 1'b1, 1'b1);
        lk_valid = 1'b1; lk_vpn = 36'h3333;
        step();
        check("R12 lookup during fill", E_MISS, '0);
        look(36'h3333, "R12 after fill", E_HIT, 28'h333);

        // R12 with flush, then R10
        inv_all = 1'b1; lk_valid = 1'b1; lk_vpn = 36'h3333;
        step();
        check("R12 lookup during flush", E_HIT, 28'h333);
        look(36'h3333, "R10 flushed 4K", E_MISS, '0);
        look(36'h1234, "R10 flushed 4K b", E_MISS, '0);
        look(36'hA03,  "R10 flushed 2M", E_MISS, '0);

        // R11: flush with fill in the same cycle
        fill(36'h4444, 28'h444);
        inv_all = 1'b1; set_fill(36'h5555, 28'h555, 2'd0, 1'b1, 1'b1);
        step();
        look(36'h5555, "R11 fill survives flush", E_HIT, 28'h555);
        look(36'h4444, "R11 old entry flushed", E_MISS, '0);
        // R11: invalidate and refill the same page together
        inv_valid = 1'b1; inv_vpn = 36'h5555; set_fill(36'h5555, 28'h5AA, 2'd0, 1'b1, 1'b1);
        step();
        look(36'h5555, "R11 refill survives inv", E_HIT, 28'h5AA);

        // R7 / R8: replacement order
        inv_all = 1'b1;
        step();
        for (int i = 0; i < 16; i++) fill(36'h1000 + 36'(i), 28'h2000 + 28'(i));
        inv_valid = 1'b1; inv_vpn = 36'h1005; step();
        inv_valid = 1'b1; inv_vpn = 36'h1009; step();
        fill(36'h3000, 28'h3000);
        fill(36'h3001, 28'h3001);
        look(36'h1000, "R7 free slots used first", E_HIT, 28'h2000);
        fill(36'h3002, 28'h3002);
        look(36'h1000, "R8 first victim is slot 0", E_MISS, '0);
        look(36'h1001, "R8 slot 1 kept", E_HIT, 28'h2001);
        look(36'h3000, "R7 fill in freed slot", E_HIT, 28'h3000);
        look(36'h3001, "R7 second freed slot", E_HIT, 28'h3001);
        look(36'h3002, "R8 replacement present", E_HIT, 28'h3002);
        fill(36'h3003, 28'h3003);
        look(36'h1001, "R8 pointer stepped to slot 1", E_MISS, '0);
        look(36'h1002, "R8 slot 2 kept", E_HIT, 28'h2002);

        // R11: full array, invalidate frees a slot in the fill cycle
        inv_valid = 1'b1; inv_vpn = 36'h1004; set_fill(36'h4000, 28'h4000, 2'd0, 1'b1, 1'b1);
        step();
        look(36'h1002, "R11 pointer victim untouched", E_HIT, 28'h2002);
        look(36'h4000, "R11 fill took freed slot", E_HIT, 28'h4000);
        look(36'h1004, "R11 invalidated entry gone", E_MISS, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule